// File: doc/BRIEF.md
# Vector Register Move and Merge Unit

This unit moves data for a small file of 128-bit vector registers, each split into four 32-bit lanes with lane 0 in the least significant position. A decoded move names a width variant, a direction and two register indices. The variants are aligned full width, unaligned full width, single low lane (scalar) and low 64-bit pair. The directions are register to register, load from memory and store to memory. Partial-width writes merge into the destination so that lanes outside the move are handled by a fixed rule. Stores drive a data bus with a byte-enable mask.

Register-to-register moves and stores finish in the cycle they are accepted. A load issues one request and waits for a valid response. Only then does it write the destination. The only variant that checks the address is the aligned full-width move. When it finds a misaligned address it raises a fault flag and does nothing else. Raising the exception is the job of the surrounding logic.

Top module: `vmove_unit`

## Requirements
- R1: After a synchronous active-low reset every register reads as zero, `mv_ready` is 1, and `mem_req` and `fault` are 0.
- R2: A full-width register-to-register move (kind 0 or 1, direction 0 or 3) copies all 128 bits of the source into the destination on the next clock edge. Kind 0 never faults in this direction, whatever the address is.
- R3: A kind-0 load or store (direction 1 or 2) whose address is not a multiple of 16 raises `fault` in the accept cycle. It asserts no `mem_req` and changes no register.
- R4: A kind-1 load or store never faults, at any byte offset, and moves all 128 bits.
- R5: A scalar (kind 2) register-to-register move writes source lane 0 into destination lane 0 and leaves destination lanes 1 to 3 unchanged.
- R6: A scalar load writes `mem_rdata[31:0]` into lane 0 and zeroes lanes 1 to 3.
- R7: A pair (kind 3) move, as a load or register to register, writes the low 64 bits of the source data into the destination and leaves its high 64 bits unchanged.
- R8: A store asserts `mem_req` and `mem_we` for one cycle at `mv_addr`. `mem_be` is 0xFFFF for kinds 0 and 1, 0x00FF for kind 3 and 0x000F for kind 2. `mem_wdata` carries the source register in the enabled bytes and zero in the others.
- R9: A load asserts `mem_req` with `mem_we`=0 in its accept cycle and then holds `mv_ready` low until `mem_rvalid`. The destination is written only on the `mem_rvalid` cycle. A move presented while `mv_ready` is low is ignored.
- R10: A move whose source and destination are the same register uses the old contents. It completes without stalling.
- R11: Scalar and pair moves never fault, at any address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mv_valid | input | 1 | Move request present |
| mv_ready | output | 1 | Unit idle; a valid move is accepted this cycle |
| mv_kind | input | 2 | 0 aligned full, 1 unaligned full, 2 scalar, 3 pair |
| mv_dir | input | 2 | 0 register to register, 1 load, 2 store, 3 same as 0 |
| mv_dst | input | 3 | Destination register index |
| mv_src | input | 3 | Source register index (register moves and stores) |
| mv_addr | input | 32 | Byte address for loads and stores |
| fault | output | 1 | Misaligned aligned-full move, accept cycle only |
| mem_req | output | 1 | Memory request, one cycle |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Request byte address |
| mem_be | output | 16 | Store byte enables |
| mem_wdata | output | 128 | Store data |
| mem_rvalid | input | 1 | Load data valid |
| mem_rdata | input | 128 | Load data |

## Verification
The embedded assertions check several things on every cycle. A fault suppresses both the memory request and the register write. Requests appear only while idle, and a load request always leads to the waiting state. No register write happens while a load waits without valid data. Store byte enables always form a contiguous run from byte 0. Only the bench scenarios can show the lane-level merge results, which it reads back through stores. These cover the zeroing versus keeping of upper lanes, the exact mask per kind, and the alignment sweep over all sixteen byte offsets. The bench scenarios also show that a move offered during a load wait leaves no trace.

// File: rtl/vmove_pkg.sv
// Shared encodings for the vector move unit.
// Assumes a two-bit kind and a two-bit direction field from the decoder.
package vmove_pkg;

    typedef enum logic [1:0] {
        MK_FULL_AL = 2'd0,
        MK_FULL_UN = 2'd1,
        MK_SCALAR  = 2'd2,
        MK_PAIR    = 2'd3
    } mv_kind_e;

    typedef enum logic [1:0] {
        MD_REG   = 2'd0,
        MD_LOAD  = 2'd1,
        MD_STORE = 2'd2,
        MD_RSVD  = 2'd3
    } mv_dir_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } mv_state_e;

endpackage

// File: rtl/vmove_regfile.sv
// Vector register file: NREGS entries of WIDTH bits.
// Two asynchronous read ports, one synchronous write port.
// Assumes every index value below 2**IDX_W names a register.
module vmove_regfile #(
    parameter int NREGS = 8,
    parameter int WIDTH = 128,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] ra_idx,
    output logic [WIDTH-1:0] ra_data,
    input  logic [IDX_W-1:0] rb_idx,
    output logic [WIDTH-1:0] rb_data,
    input  logic             we,
    input  logic [IDX_W-1:0] w_idx,
    input  logic [WIDTH-1:0] w_data
);

    logic [WIDTH-1:0] regs_q [NREGS];

    // Clear all entries on reset; write one entry when enabled.
    always_ff @(posedge clk) begin
        for (int r = 0; r < NREGS; r++) begin
            if (!rst_n) begin
                regs_q[r] <= '0;
            end else if (we && (w_idx == IDX_W'(r))) begin
                regs_q[r] <= w_data;
            end
        end
    end

    // Combinational read ports return pre-edge contents.
    always_comb begin
        ra_data = regs_q[ra_idx];
        rb_data = regs_q[rb_idx];
    end

endmodule

// File: rtl/vmove_lane_merge.sv
// Lane merge: the low lanes selected by the move kind come from new_vec.
// The remaining lanes come from old_vec, or are zero when clear_upper is set.
// Assumes LANES >= 2.
module vmove_lane_merge
    import vmove_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 32,
    localparam int VEC_W = LANES * LANE_W,
    localparam int CNT_W = $clog2(LANES + 1)
) (
    input  mv_kind_e         kind,
    input  logic             clear_upper,
    input  logic [VEC_W-1:0] old_vec,
    input  logic [VEC_W-1:0] new_vec,
    output logic [VEC_W-1:0] out_vec
);

    logic [CNT_W-1:0] n_new;

    // Number of low lanes the move kind replaces.
    always_comb begin
        case (kind)
            MK_SCALAR: n_new = CNT_W'(1);
            MK_PAIR:   n_new = CNT_W'(2);
            default:   n_new = CNT_W'(LANES);
        endcase
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        // Per-lane source choice.
        assign out_vec[l*LANE_W +: LANE_W] =
            (CNT_W'(l) < n_new)  ? new_vec[l*LANE_W +: LANE_W] :
            clear_upper          ? '0 :
                                   old_vec[l*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/vmove_addr_check.sv
// Alignment check and byte-enable generation for one move.
// Only the aligned full-width kind checks alignment, and only when it
// touches memory. Assumes BYTES is a power of two.
module vmove_addr_check
    import vmove_pkg::*;
#(
    parameter int BYTES      = 16,
    parameter int LANE_BYTES = 4,
    localparam int ALIGN_W   = $clog2(BYTES),
    localparam int CNT_W     = $clog2(BYTES + 1)
) (
    input  mv_kind_e           kind,
    input  mv_dir_e            dir,
    input  logic [ALIGN_W-1:0] addr_lo,
    output logic               misaligned,
    output logic [BYTES-1:0]   byte_en
);

    logic [CNT_W-1:0] n_bytes;

    // Fault only for aligned full-width memory moves off a BYTES boundary.
    always_comb begin
        misaligned = (kind == MK_FULL_AL) &&
                     ((dir == MD_LOAD) || (dir == MD_STORE)) &&
                     (addr_lo != '0);
    end

    // Bytes covered by the move kind.
    always_comb begin
        case (kind)
            MK_SCALAR: n_bytes = CNT_W'(LANE_BYTES);
            MK_PAIR:   n_bytes = CNT_W'(2 * LANE_BYTES);
            default:   n_bytes = CNT_W'(BYTES);
        endcase
    end

    for (genvar b = 0; b < BYTES; b++) begin : g_be
        // Enable the low n_bytes bytes.
        assign byte_en[b] = (CNT_W'(b) < n_bytes);
    end

endmodule

// File: rtl/vmove_unit.sv
// Vector register move and merge unit (top).
// Accepts one move per cycle while idle. Register moves and stores finish in
// the accept cycle and register writes land on the following edge. A load
// issues one request and waits in ST_WAIT for mem_rvalid. Assumes the memory
// returns exactly one response per load request.
module vmove_unit
    import vmove_pkg::*;
#(
    parameter int NREGS  = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 32,
    parameter int ADDR_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        mv_valid,
    output logic                        mv_ready,
    input  logic [1:0]                  mv_kind,
    input  logic [1:0]                  mv_dir,
    input  logic [$clog2(NREGS)-1:0]    mv_dst,
    input  logic [$clog2(NREGS)-1:0]    mv_src,
    input  logic [ADDR_W-1:0]           mv_addr,
    output logic                        fault,
    output logic                        mem_req,
    output logic                        mem_we,
    output logic [ADDR_W-1:0]           mem_addr,
    output logic [LANES*LANE_W/8-1:0]   mem_be,
    output logic [LANES*LANE_W-1:0]     mem_wdata,
    input  logic                        mem_rvalid,
    input  logic [LANES*LANE_W-1:0]     mem_rdata
);

    localparam int IDX_W      = $clog2(NREGS);
    localparam int VEC_W      = LANES * LANE_W;
    localparam int BYTES      = VEC_W / 8;
    localparam int LANE_BYTES = LANE_W / 8;
    localparam int ALIGN_W    = $clog2(BYTES);

    mv_kind_e   kind;
    mv_dir_e    dir;
    mv_state_e  st_q;
    logic [IDX_W-1:0] pend_dst_q;
    mv_kind_e   pend_kind_q;

    logic             accept;
    logic             is_reg;
    logic             is_mem;
    logic             misaligned;
    logic [BYTES-1:0] byte_en;
    logic             waiting;

    logic [IDX_W-1:0] rb_idx;
    logic [VEC_W-1:0] src_data;
    logic [VEC_W-1:0] dst_data;
    logic [VEC_W-1:0] wb_new;
    logic [VEC_W-1:0] wb_data;
    logic [VEC_W-1:0] st_data;
    mv_kind_e         wb_kind;
    logic             wb_clear;
    logic             rf_we;

    // Decode the raw port fields.
    always_comb begin
        kind    = mv_kind_e'(mv_kind);
        dir     = mv_dir_e'(mv_dir);
        is_reg  = (dir == MD_REG) || (dir == MD_RSVD);
        is_mem  = (dir == MD_LOAD) || (dir == MD_STORE);
        waiting = (st_q == ST_WAIT);
        accept  = mv_valid && !waiting;
    end

    vmove_addr_check #(
        .BYTES      (BYTES),
        .LANE_BYTES (LANE_BYTES)
    ) u_addr (
        .kind       (kind),
        .dir        (dir),
        .addr_lo    (mv_addr[ALIGN_W-1:0]),
        .misaligned (misaligned),
        .byte_en    (byte_en)
    );

    // Handshake and memory request outputs.
    always_comb begin
        mv_ready  = !waiting;
        fault     = accept && misaligned;
        mem_req   = accept && is_mem && !misaligned;
        mem_we    = mem_req && (dir == MD_STORE);
        mem_addr  = mv_addr;
        mem_be    = mem_we ? byte_en : '0;
        mem_wdata = mem_we ? st_data : '0;
    end

    // Load tracking: remember the destination and kind until data returns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= ST_IDLE;
            pend_dst_q  <= '0;
            pend_kind_q <= MK_FULL_AL;
        end else if (waiting) begin
            if (mem_rvalid) st_q <= ST_IDLE;
        end else if (mem_req && !mem_we) begin
            st_q        <= ST_WAIT;
            pend_dst_q  <= mv_dst;
            pend_kind_q <= kind;
        end
    end

    // Write-back source selection: register move now, or returning load.
    always_comb begin
        rb_idx   = waiting ? pend_dst_q  : mv_dst;
        wb_kind  = waiting ? pend_kind_q : kind;
        wb_new   = waiting ? mem_rdata   : src_data;
        wb_clear = waiting && (pend_kind_q == MK_SCALAR);
        rf_we    = (accept && is_reg) || (waiting && mem_rvalid);
    end

    vmove_regfile #(
        .NREGS (NREGS),
        .WIDTH (VEC_W)
    ) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .ra_idx  (mv_src),
        .ra_data (src_data),
        .rb_idx  (rb_idx),
        .rb_data (dst_data),
        .we      (rf_we),
        .w_idx   (rb_idx),
        .w_data  (wb_data)
    );

    vmove_lane_merge #(
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_wb_merge (
        .kind        (wb_kind),
        .clear_upper (wb_clear),
        .old_vec     (dst_data),
        .new_vec     (wb_new),
        .out_vec     (wb_data)
    );

    vmove_lane_merge #(
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_st_merge (
        .kind        (kind),
        .clear_upper (1'b1),
        .old_vec     ('0),
        .new_vec     (src_data),
        .out_vec     (st_data)
    );

    // R3: a fault blocks both memory traffic and register write-back.
    a_r3_fault_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (!mem_req && !rf_we));

    // R11: only the aligned full-width kind at a misaligned address faults.
    a_r11_fault_source: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (mv_kind == 2'd0 && mv_addr[ALIGN_W-1:0] != '0));

    // R9: requests only while idle; a load request leads into the wait state.
    a_r9_req_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mv_ready);
    a_r9_load_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |=> !mv_ready);
    a_r9_no_early_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!mv_ready && !mem_rvalid) |-> !rf_we);

    // R8: store byte enables are a contiguous run starting at byte 0.
    a_r8_be_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_be[0] &&
                    (((mem_be + {{(BYTES-1){1'b0}}, 1'b1}) & mem_be) == '0)));

endmodule

// File: tb/tb_vmove_unit.sv
module tb_vmove_unit;

    localparam logic [1:0] K_AL = 2'd0, K_UN = 2'd1, K_SC = 2'd2, K_PR = 2'd3;
    localparam logic [1:0] D_REG = 2'd0, D_LD = 2'd1, D_ST = 2'd2;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         mv_valid;
    logic         mv_ready;
    logic [1:0]   mv_kind;
    logic [1:0]   mv_dir;
    logic [2:0]   mv_dst;
    logic [2:0]   mv_src;
    logic [31:0]  mv_addr;
    logic         fault;
    logic         mem_req;
    logic         mem_we;
    logic [31:0]  mem_addr;
    logic [15:0]  mem_be;
    logic [127:0] mem_wdata;
    logic         mem_rvalid;
    logic [127:0] mem_rdata;

    vmove_unit dut (
        .clk(clk), .rst_n(rst_n), .mv_valid(mv_valid), .mv_ready(mv_ready),
        .mv_kind(mv_kind), .mv_dir(mv_dir), .mv_dst(mv_dst), .mv_src(mv_src),
        .mv_addr(mv_addr), .fault(fault), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    always #2 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    logic [127:0] model [8];

    logic         c_req, c_we, c_fault, c_ready;
    logic [15:0]  c_be;
    logic [127:0] c_wd;
    logic [31:0]  c_addr;

    function automatic logic [127:0] pat(input int n);
        logic [127:0] v;
        for (int j = 0; j < 4; j++)
            v[j*32 +: 32] = (32'h9E3779B9 * 32'(n*4 + j + 1)) ^ 32'h5A5A0000;
        return v;
    endfunction

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic move(input logic [1:0] k, input logic [1:0] d, input int dst,
                        input int src, input logic [31:0] a);
        @(negedge clk);
        mv_valid = 1'b1; mv_kind = k; mv_dir = d;
        mv_dst = 3'(dst); mv_src = 3'(src); mv_addr = a;
        #1;
        c_req = mem_req; c_we = mem_we; c_fault = fault; c_ready = mv_ready;
        c_be = mem_be; c_wd = mem_wdata; c_addr = mem_addr;
        @(posedge clk); #1;
        mv_valid = 1'b0;
    endtask

    task automatic read_reg(input int idx, output logic [127:0] v);
        move(K_UN, D_ST, 0, idx, 32'h200 + 32'(idx * 3));
        v = c_wd;
    endtask

    task automatic give_data(input logic [127:0] data, input int dly);
        repeat (dly) @(negedge clk);
        @(negedge clk);
        mem_rvalid = 1'b1; mem_rdata = data;
        @(posedge clk); #1;
        mem_rvalid = 1'b0;
    endtask

    function automatic string ktag(input logic [1:0] k);
        case (k)
            K_SC:    return "R5 scalar reg move";
            K_PR:    return "R7 pair reg move";
            default: return "R2 full reg move";
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog: run did not finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [127:0] v, exp, data;
        logic [31:0] a;
        mv_valid = 0; mv_kind = 0; mv_dir = 0; mv_dst = 0; mv_src = 0;
        mv_addr = 0; mem_rvalid = 0; mem_rdata = '0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs in reset state
        chk("R1 reset ready/req/fault", {125'b0, mv_ready, mem_req, fault}, {125'b0, 3'b100});
        rst_n = 1'b1;
        for (int r = 0; r < 8; r++) begin
            read_reg(r, v);
            chk("R1 register zero after reset", v, '0);
        end

        // Scenario: register-to-register sweep, every kind and every pair.
        for (int k = 0; k < 4; k++) begin
            for (int r = 0; r < 8; r++) begin
                move(K_UN, D_LD, r, 0, 32'h1000 + 32'(r*16 + 5));
                // R4: unaligned full load at offset 5 does not fault
                chk("R4 unaligned load no fault", {126'b0, c_fault, c_req}, 128'd1);
                give_data(pat(r + k*8), r % 3);
                model[r] = pat(r + k*8);
            end
            for (int d = 0; d < 8; d++) begin
                for (int s = 0; s < 8; s++) begin
                    move(2'(k), (s == 7) ? 2'd3 : D_REG, d, s, 32'h3);
                    chk("R2 reg move no request/fault", {126'b0, c_req, c_fault}, '0);
                    case (2'(k))
                        K_SC:    exp = {model[d][127:32], model[s][31:0]};
                        K_PR:    exp = {model[d][127:64], model[s][63:0]};
                        default: exp = model[s];
                    endcase
                    model[d] = exp;
                    read_reg(d, v);
                    if (d == s) chk("R10 same src/dst", v, exp);
                    else        chk(ktag(2'(k)), v, exp);
                end
            end
        end

        // Scenario: loads of every kind into every register at all 16 offsets.
        for (int k = 0; k < 4; k++) begin
            for (int d = 0; d < 8; d++) begin
                for (int off = 0; off < 16; off++) begin
                    a = 32'h4000 + 32'(d*64) + 32'(off);
                    data = pat(100 + k*128 + d*16 + off);
                    move(2'(k), D_LD, d, 0, a);
                    if (k == 0 && off != 0) begin
                        // R3: misaligned aligned-full load faults, no request
                        chk("R3 load fault/no req", {126'b0, c_fault, c_req}, 128'd2);
                        chk("R9 ready after fault", {127'b0, mv_ready}, 128'd1);
                    end else begin
                        if (k >= 2) chk("R11 partial load no fault", {127'b0, c_fault}, '0);
                        chk("R9 load request", {95'b0, c_req, c_we, c_addr}, {95'b0, 1'b1, 1'b0, a});
                        if (off % 3 != 0) begin
                            @(negedge clk);
                            chk("R9 busy while waiting", {126'b0, mv_ready, mem_req}, '0);
                        end
                        give_data(data, 0);
                        case (2'(k))
                            K_SC:    model[d] = {96'b0, data[31:0]};
                            K_PR:    model[d] = {model[d][127:64], data[63:0]};
                            default: model[d] = data;
                        endcase
                    end
                    read_reg(d, v);
                    if (k == 0 && off != 0) chk("R3 register unchanged", v, model[d]);
                    else if (k == 2)        chk("R6 scalar load zeroes upper", v, model[d]);
                    else if (k == 3)        chk("R7 pair load keeps upper", v, model[d]);
                    else                    chk("R4 full load", v, model[d]);
                end
            end
        end

        // Scenario: stores of every kind from every register at several offsets.
        for (int k = 0; k < 4; k++) begin
            for (int s = 0; s < 8; s++) begin
                for (int off = 0; off < 16; off += 4) begin
                    a = 32'h8000 + 32'(s*32) + 32'(off);
                    move(2'(k), D_ST, 0, s, a);
                    if (k == 0 && off != 0) begin
                        chk("R3 store fault/no req", {125'b0, c_fault, c_req, c_we}, 128'd4);
                    end else begin
                        case (2'(k))
                            K_SC:    begin exp = {96'b0, model[s][31:0]}; v = 128'h000F; end
                            K_PR:    begin exp = {64'b0, model[s][63:0]}; v = 128'h00FF; end
                            default: begin exp = model[s];                v = 128'hFFFF; end
                        endcase
                        chk("R8 store req/we/addr", {94'b0, c_req, c_we, c_fault, c_addr},
                            {94'b0, 1'b1, 1'b1, 1'b0, a});
                        chk("R8 store byte enables", {112'b0, c_be}, v);
                        chk("R8 store data", c_wd, exp);
                    end
                end
            end
        end

        // Scenario: a move offered during a load wait is ignored.
        move(K_UN, D_LD, 2, 0, 32'h9001);
        @(negedge clk);
        mv_valid = 1'b1; mv_kind = K_UN; mv_dir = D_REG; mv_dst = 3'd2; mv_src = 3'd5;
        #1;
        chk("R9 move ignored while busy", {126'b0, mv_ready, mem_req}, '0);
        @(posedge clk); #1;
        mv_valid = 1'b0;
        give_data(pat(999), 1);
        model[2] = pat(999);
        read_reg(2, v);
        chk("R9 load data written, offered move dropped", v, model[2]);
        read_reg(5, v);
        chk("R9 source register untouched", v, model[5]);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule